// File: doc/BRIEF.md
# Dynamic Voltage Scaling Ramp Controller

This block produces the 7-bit setpoint code for a regulator's reference DAC. The output voltage is 0.4 V plus 12.5 mV for each code step, so the code range covers 0.400 V to 1.9875 V. A select input chooses one of two setpoint values as the target. When the target differs from the present code, the code moves one step at a time toward it. A 2-bit slew field sets the pace, and time is counted in quarter-microsecond ticks.

The same block drives a registered request for forced-PWM operation and a busy flag that stays high while a ramp is in progress. The software enable and the register-reset pulse both force the code to zero. After either one, a fresh start-up ramp runs from zero to the selected target.

Top module: `dvs_ramp_ctrl`

## Requirements
- R1: After `rst` the outputs are `dac_code`=0, `busy`=0 and `pwm_req`=0.
- R2: The target is `setpt_a` when `sel_hi`=0 and `setpt_b[6:0]` when `sel_hi`=1. The code settles at the selected target.
- R3: Each change of `dac_code` other than a forced zero is exactly +1 or -1, in the direction of the current target. If the target changes during a ramp, the ramp continues from the present code with no jump.
- R4: `slew_sel` 00, 01, 10 and 11 give one step every 5, 10, 50 and 500 `qtick` pulses (10, 5, 1 and 0.1 mV/µs). Tick counting starts with the first clock edge at which the code differs from the target, and the code changes only on edges where `qtick` is high.
- R5: `busy` is registered. It rises on the first edge after the target differs from the code, and it falls on the same edge at which the code reaches the target.
- R6: `pwm_req` is registered one edge after its inputs. It is 1 when enabled and at least one of these holds: `pwm_global` is set; `sel_hi`=1 and `setpt_b[7]`=1; or `pwm_on_change`=1 while the code has not yet reached the target.
- R7: While `enable`=0, the next edge forces `dac_code`=0, `busy`=0 and `pwm_req`=0. Raising `enable` again starts a ramp from 0 at the configured rate.
- R8: A one-cycle `soft_rst` forces the code to 0 at the next edge and clears the step timer. The ramp then restarts from 0, and its first step comes a full interval later.
- R9: `setpt_b[7]` has no effect on the code target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Software enable; 0 holds the code at zero |
| soft_rst | input | 1 | Register-reset pulse; aborts the ramp |
| sel_hi | input | 1 | Setpoint select: 0 = A, 1 = B |
| setpt_a | input | 7 | Setpoint A code |
| setpt_b | input | 8 | Bit 7 = PWM lock for setpoint B; bits 6:0 = setpoint B code |
| slew_sel | input | 2 | Ramp speed select |
| pwm_global | input | 1 | Global forced-PWM request |
| pwm_on_change | input | 1 | Force PWM while ramping |
| qtick | input | 1 | Quarter-microsecond timebase pulse |
| dac_code | output | 7 | Setpoint code to the DAC |
| pwm_req | output | 1 | Forced-PWM request |
| busy | output | 1 | Ramp in progress |

## Verification
The assertions check on every cycle that:
- the code moves by one step at most;
- a code change other than a forced zero only follows a timer step;
- disable and soft reset leave the code at zero and `pwm_req` and `busy` low;
- the tick counter stays inside its longest interval.

Only the bench scenarios can show:
- the exact number of ticks per step for each slew code;
- the direction after a retarget mid-ramp;
- the cycle on which `busy` falls;
- the complete truth table of the PWM request.

// File: rtl/dvs_pkg.sv
package dvs_pkg;
  typedef enum logic [1:0] {
    SLEW_FAST  = 2'b00,
    SLEW_MED   = 2'b01,
    SLEW_SLOW  = 2'b10,
    SLEW_CRAWL = 2'b11
  } slew_e;
endpackage

// File: rtl/dvs_step_timer.sv
module dvs_step_timer #(
  parameter int unsigned TICKS_FAST  = 5,
  parameter int unsigned TICKS_MED   = 10,
  parameter int unsigned TICKS_SLOW  = 50,
  parameter int unsigned TICKS_CRAWL = 500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       run,
  input  logic       qtick,
  input  logic [1:0] slew,
  output logic       step
);
  import dvs_pkg::*;

  localparam int unsigned MAX_AB = (TICKS_FAST > TICKS_MED) ? TICKS_FAST : TICKS_MED;
  localparam int unsigned MAX_CD = (TICKS_SLOW > TICKS_CRAWL) ? TICKS_SLOW : TICKS_CRAWL;
  localparam int unsigned TMAX   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int unsigned CNT_W  = $clog2(TMAX + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;

  always_comb begin
    unique case (slew_e'(slew))
      SLEW_FAST:  last_cnt = CNT_W'(TICKS_FAST - 1);
      SLEW_MED:   last_cnt = CNT_W'(TICKS_MED - 1);
      SLEW_SLOW:  last_cnt = CNT_W'(TICKS_SLOW - 1);
      default:    last_cnt = CNT_W'(TICKS_CRAWL - 1);
    endcase
  end

  assign step = run && qtick && (cnt_q >= last_cnt);

  always_ff @(posedge clk) begin
    if (rst || clr || !run) begin
      cnt_q <= '0;
    end else if (qtick) begin
      if (cnt_q >= last_cnt) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CNT_W'(TMAX));
endmodule

// File: rtl/dvs_code_stepper.sv
module dvs_code_stepper #(
  parameter int unsigned CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              force_zero,
  input  logic [CODE_W-1:0] target,
  input  logic              step,
  output logic [CODE_W-1:0] code_q,
  output logic [CODE_W-1:0] code_nxt,
  output logic              ramping
);
  localparam logic [CODE_W-1:0] ONE  = CODE_W'(1);
  localparam logic [CODE_W-1:0] MONE = {CODE_W{1'b1}};

  assign ramping = (code_q != target);

  always_comb begin
    if (force_zero)
      code_nxt = '0;
    else if (step && ramping)
      code_nxt = (code_q < target) ? code_q + ONE : code_q - ONE;
    else
      code_nxt = code_q;
  end

  always_ff @(posedge clk) begin
    if (rst) code_q <= '0;
    else     code_q <= code_nxt;
  end

  // R3
  step_by_one_chk: assert property (@(posedge clk) disable iff (rst)
    (code_q != $past(code_q)) |->
      ((code_q - $past(code_q)) == ONE || (code_q - $past(code_q)) == MONE || code_q == '0));

  // R4
  step_gated_chk: assert property (@(posedge clk) disable iff (rst)
    (code_q != $past(code_q) && code_q != '0) |-> $past(step));

  // R8
  zero_on_force_chk: assert property (@(posedge clk) disable iff (rst)
    $past(force_zero) |-> (code_q == '0));
endmodule

// File: rtl/dvs_mode_sel.sv
module dvs_mode_sel (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic global_pwm,
  input  logic lock_pwm,
  input  logic change_pwm,
  input  logic ramp_next,
  output logic pwm_q
);
  logic pwm_nxt;

  assign pwm_nxt = en && (global_pwm || lock_pwm || (change_pwm && ramp_next));

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= pwm_nxt;
  end

  // R7
  pwm_off_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!en) |-> !pwm_q);
endmodule

// File: rtl/dvs_ramp_ctrl.sv
module dvs_ramp_ctrl #(
  parameter int unsigned CODE_W      = 7,
  parameter int unsigned TICKS_FAST  = 5,
  parameter int unsigned TICKS_MED   = 10,
  parameter int unsigned TICKS_SLOW  = 50,
  parameter int unsigned TICKS_CRAWL = 500
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              soft_rst,
  input  logic              sel_hi,
  input  logic [CODE_W-1:0] setpt_a,
  input  logic [CODE_W:0]   setpt_b,
  input  logic [1:0]        slew_sel,
  input  logic              pwm_global,
  input  logic              pwm_on_change,
  input  logic              qtick,
  output logic [CODE_W-1:0] dac_code,
  output logic              pwm_req,
  output logic              busy
);
  logic [CODE_W-1:0] target;
  logic [CODE_W-1:0] code_nxt;
  logic              force_zero;
  logic              ramping;
  logic              step;
  logic              busy_nxt;
  logic              busy_q;

  assign target     = sel_hi ? setpt_b[CODE_W-1:0] : setpt_a;
  assign force_zero = !enable || soft_rst;
  assign busy_nxt   = !force_zero && (code_nxt != target);

  dvs_step_timer #(
    .TICKS_FAST (TICKS_FAST),
    .TICKS_MED  (TICKS_MED),
    .TICKS_SLOW (TICKS_SLOW),
    .TICKS_CRAWL(TICKS_CRAWL)
  ) timer_i (
    .clk  (clk),
    .rst  (rst),
    .clr  (force_zero),
    .run  (ramping),
    .qtick(qtick),
    .slew (slew_sel),
    .step (step)
  );

  dvs_code_stepper #(.CODE_W(CODE_W)) stepper_i (
    .clk       (clk),
    .rst       (rst),
    .force_zero(force_zero),
    .target    (target),
    .step      (step),
    .code_q    (dac_code),
    .code_nxt  (code_nxt),
    .ramping   (ramping)
  );

  dvs_mode_sel mode_i (
    .clk       (clk),
    .rst       (rst),
    .en        (!force_zero),
    .global_pwm(pwm_global),
    .lock_pwm  (sel_hi && setpt_b[CODE_W]),
    .change_pwm(pwm_on_change),
    .ramp_next (busy_nxt),
    .pwm_q     (pwm_req)
  );

  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else     busy_q <= busy_nxt;
  end
  assign busy = busy_q;

  // R7
  busy_off_chk: assert property (@(posedge clk) disable iff (rst)
    $past(force_zero) |-> !busy);
endmodule

// File: tb/dvs_ramp_ctrl_tb_top.sv
module dvs_ramp_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic       soft_rst = 1'b0;
  logic       sel_hi = 1'b0;
  logic [6:0] setpt_a = '0;
  logic [7:0] setpt_b = '0;
  logic [1:0] slew_sel = 2'b00;
  logic       pwm_global = 1'b0;
  logic       pwm_on_change = 1'b0;
  logic       qtick = 1'b1;
  logic [6:0] dac_code;
  logic       pwm_req;
  logic       busy;

  int errors = 0;
  int checks = 0;

  // {global, sel_hi, setpt_b[7], expected pwm_req}
  localparam logic [3:0] PWM_VEC [8] = '{
    4'b000_0, 4'b001_0, 4'b010_0, 4'b011_1,
    4'b100_1, 4'b101_1, 4'b110_1, 4'b111_1
  };

  always #10 clk = ~clk;

  dvs_ramp_ctrl dut_i (
    .clk(clk), .rst(rst), .enable(enable), .soft_rst(soft_rst),
    .sel_hi(sel_hi), .setpt_a(setpt_a), .setpt_b(setpt_b),
    .slew_sel(slew_sel), .pwm_global(pwm_global),
    .pwm_on_change(pwm_on_change), .qtick(qtick),
    .dac_code(dac_code), .pwm_req(pwm_req), .busy(busy)
  );

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    adv(3);
    chk("R1 code after reset", dac_code, 0);
    chk("R1 busy after reset", busy, 0);
    chk("R1 pwm after reset", pwm_req, 0);
    rst = 1'b0;
    enable = 1'b1;
    adv(1);

    // R6 and R9 table walk; the target stays 0
    for (int i = 0; i < 8; i++) begin
      pwm_global = PWM_VEC[i][3];
      sel_hi     = PWM_VEC[i][2];
      setpt_b    = {PWM_VEC[i][1], 7'd0};
      adv(1);
      chk("R6 pwm table", pwm_req, PWM_VEC[i][0]);
      chk("R9 lock bit ignored for code", dac_code, 0);
    end
    pwm_global = 1'b0; sel_hi = 1'b0; setpt_b = 8'd0;
    adv(1);

    // R4 and R5 at the fastest rate
    setpt_a = 7'd3; slew_sel = 2'b00;
    adv(1);
    chk("R5 busy rises", busy, 1);
    adv(3);
    chk("R4 no step before 5 ticks", dac_code, 0);
    adv(1);
    chk("R4 step at 5 ticks", dac_code, 1);
    adv(10);
    chk("R2 settles on setpoint A", dac_code, 3);
    chk("R5 busy falls at target", busy, 0);

    // R2 select B at the 01 rate
    setpt_b = 8'h05; sel_hi = 1'b1; slew_sel = 2'b01;
    adv(9);
    chk("R4 no step before 10 ticks", dac_code, 3);
    adv(1);
    chk("R4 step at 10 ticks", dac_code, 4);
    adv(10);
    chk("R2 settles on setpoint B", dac_code, 5);

    // R3 ramp down, then retarget mid-ramp
    sel_hi = 1'b0; setpt_a = 7'd0; slew_sel = 2'b00;
    adv(5);
    chk("R3 ramp down one step", dac_code, 4);
    setpt_a = 7'd2;
    adv(5);
    chk("R3 retarget continues from code", dac_code, 3);
    adv(5);
    chk("R3 retarget settles", dac_code, 2);
    chk("R5 busy low after retarget", busy, 0);

    // R6 forced PWM while ramping
    pwm_on_change = 1'b1; setpt_a = 7'd6;
    adv(1);
    chk("R6 pwm during ramp", pwm_req, 1);
    adv(19);
    chk("R6 ramp done code", dac_code, 6);
    chk("R6 pwm drops at target", pwm_req, 0);
    pwm_on_change = 1'b0;

    // R4 no step without qtick
    setpt_a = 7'd7; qtick = 1'b0;
    adv(20);
    chk("R4 no step without qtick", dac_code, 6);
    qtick = 1'b1;
    adv(5);
    chk("R4 step after ticks resume", dac_code, 7);

    // R4 slowest rate, then the 10 rate
    setpt_a = 7'd8; slew_sel = 2'b11;
    adv(499);
    chk("R4 no step before 500 ticks", dac_code, 7);
    adv(1);
    chk("R4 step at 500 ticks", dac_code, 8);
    setpt_a = 7'd9; slew_sel = 2'b10;
    adv(49);
    chk("R4 no step before 50 ticks", dac_code, 8);
    adv(1);
    chk("R4 step at 50 ticks", dac_code, 9);

    // R8 soft reset mid-ramp
    setpt_a = 7'd20; slew_sel = 2'b00;
    adv(7);
    chk("R8 ramp before soft reset", dac_code, 10);
    soft_rst = 1'b1;
    adv(1);
    soft_rst = 1'b0;
    chk("R8 code zero after soft reset", dac_code, 0);
    chk("R8 busy low after soft reset", busy, 0);
    adv(4);
    chk("R8 timer cleared", dac_code, 0);
    adv(1);
    chk("R8 restart ramp", dac_code, 1);

    // R7 disable and re-enable
    enable = 1'b0; pwm_global = 1'b1;
    adv(1);
    chk("R7 code zero when disabled", dac_code, 0);
    chk("R7 busy low when disabled", busy, 0);
    chk("R7 pwm low when disabled", pwm_req, 0);
    adv(10);
    chk("R7 code held zero", dac_code, 0);
    enable = 1'b1; pwm_global = 1'b0;
    adv(5);
    chk("R7 start-up ramp from zero", dac_code, 1);

    // R1 reset in mid-operation
    rst = 1'b1;
    adv(1);
    chk("R1 code after mid reset", dac_code, 0);
    chk("R1 busy after mid reset", busy, 0);
    rst = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule